// File: doc/BRIEF.md
# Multi-Channel Reloadable Down-Counter Timer

This block holds two or three independent 32-bit down-counters on a small memory-mapped register bus. Each channel counts one step per tick of its own prescaler, which divides the core clock by a power of four picked from a 3-bit code. When a counter that already holds zero receives another tick, it reloads from its reload register, raises a sticky underflow flag and, if that channel's interrupt enable is set, drives its interrupt line.

Software gets periodic operation by loading the same period into the reload and counter registers. It gets a one-shot by loading the reload register with all ones and the counter with the delay. A counter left free-running from all ones reads as an inverted up-count. A single byte-wide run register holds one run bit per channel. Counting happens only while a channel's run bit is set.

Top module: `tmr_unit`

## Requirements
- R1: After reset the run register and all control registers read 0, every counter and reload register reads 0xFFFFFFFF, and all interrupt outputs are low.
- R2: The address map uses byte offsets. The run register is at offset 4, and its bit n is channel n's run bit. Channel n's reload register is at 8+12n, its counter at 12+12n and its control register at 16+12n. Read data appears one cycle after `rd_en`. Any other offset reads 0. Run-register bits at or above NUM_CH are dropped.
- R3: A counter decrements by one on each tick of its prescaler while its run bit is set. With the run bit clear it holds its value, and software can write it freely. A bus write to the counter takes priority over a tick in the same cycle.
- R4: Control bits [2:0] select the tick rate. Codes 0, 1, 2, 3 and 4 give one tick every 4, 16, 64, 256 and 1024 clock cycles. After the clock edge that sets the run bit, the first tick falls on the div-th following edge.
- R5: Codes 5, 6 and 7 produce no ticks, so the counter holds its value even while the run bit is set.
- R6: A tick that finds the counter at 0 reloads the counter from its reload register and sets the underflow flag, control bit 8.
- R7: The underflow flag is sticky. A control write with bit 8 equal to 0 clears it. A control write with bit 8 equal to 1 leaves it unchanged.
- R8: Each channel's interrupt output is a register that follows (flag AND enable) one clock later. The enable is control bit 5.
- R9: A channel's prescaler phase restarts from zero each time its run bit is set again, so a partial prescaler count from an earlier run is lost.
- R10: Channels are independent: running one channel leaves another channel's counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq | output | NUM_CH | Per-channel interrupt level |

## Verification
Writes land on the edge where `wr_en` is sampled. Read data comes one edge after `rd_en`. An interrupt follows its flag and enable one edge later. With a run bit set at edge E0 and cleared by a write sampled W edges later, the channel sees floor((W+1)/div) ticks, because the edge that clears the bit still counts. The bench drives on falling edges and samples on falling edges. It computes every expected counter value from that tick count, and it reads the interrupt only after its one-cycle register delay has settled. Directed steps probe that delay directly, first in the cycle right after the enable write and again one cycle later.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W       = 32;
    localparam int CTRL_W      = 16;
    localparam int PSC_W       = 10;
    localparam int PSC_MAXCODE = 4;
    localparam int IE_BIT      = 5;
    localparam int UF_BIT      = 8;
    localparam int RUN_OFS     = 4;
    localparam int CH_OFS0     = 8;
    localparam int CH_STRIDE   = 12;
    localparam int SUB_RELOAD  = 0;
    localparam int SUB_COUNT   = 4;
    localparam int SUB_CTRL    = 8;

    typedef struct packed {
        logic       flag;
        logic       ie;
        logic [2:0] psc;
    } ctrl_t;

    function automatic int reg_ofs(input int ch, input int sub);
        return CH_OFS0 + CH_STRIDE * ch + sub;
    endfunction

    function automatic logic psc_valid(input logic [2:0] code);
        return int'(code) <= PSC_MAXCODE;
    endfunction

    function automatic logic [PSC_W-1:0] psc_limit(input logic [2:0] code);
        logic [PSC_W+1:0] full;
        full = (PSC_W+2)'(1) << (2 * int'(code) + 2);
        return PSC_W'(full - 1'b1);
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_word(input ctrl_t c);
        logic [CTRL_W-1:0] w;
        w = '0;
        w[2:0]   = c.psc;
        w[IE_BIT] = c.ie;
        w[UF_BIT] = c.flag;
        return w;
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] code,
    output logic       tick
);
    logic [PSC_W-1:0] pcnt_q;
    logic             valid;

    always_comb begin
        valid = psc_valid(code);
        tick  = run && valid && (pcnt_q >= psc_limit(code));
    end

    always_ff @(posedge clk) begin
        if (rst || !run)    pcnt_q <= '0;
        else if (tick)      pcnt_q <= '0;
        else if (valid)     pcnt_q <= pcnt_q + 1'b1;
    end

    // R9
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pcnt_q == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              reload_wr,
    input  logic              count_wr,
    input  logic              ctrl_wr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  reload_q,
    output logic [CNT_W-1:0]  count_q,
    output logic [CTRL_W-1:0] ctrl_rd,
    output logic              irq
);
    ctrl_t ctrl_q;
    logic  tick;
    logic  uf;

    tmr_prescaler u_psc (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .code (ctrl_q.psc),
        .tick (tick)
    );

    always_comb begin
        uf      = tick && (count_q == '0);
        ctrl_rd = ctrl_word(ctrl_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '1;
            count_q  <= '1;
            ctrl_q   <= '0;
            irq      <= 1'b0;
        end else begin
            if (reload_wr) reload_q <= wdata;
            if (count_wr)  count_q  <= wdata;
            else if (tick) count_q  <= uf ? reload_q : count_q - 1'b1;
            if (ctrl_wr) begin
                ctrl_q.psc <= wdata[2:0];
                ctrl_q.ie  <= wdata[IE_BIT];
            end
            ctrl_q.flag <= uf || (ctrl_q.flag && !(ctrl_wr && !wdata[UF_BIT]));
            irq         <= ctrl_q.flag && ctrl_q.ie;
        end
    end

    // R3
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !count_wr) |=> $stable(count_q));
    // R5
    reserved_code_chk: assert property (@(posedge clk) disable iff (rst)
        (!psc_valid(ctrl_q.psc) && !count_wr) |=> $stable(count_q));
    // R6
    underflow_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && count_q == '0 && !count_wr) |=> (count_q == $past(reload_q)) && ctrl_q.flag);
    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.flag && !ctrl_wr) |=> ctrl_q.flag);
    // R8
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(ctrl_q.flag && ctrl_q.ie));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NUM_CH-1:0] irq
);
    logic [NUM_CH-1:0] run_q;
    logic [CNT_W-1:0]  reload_v [NUM_CH];
    logic [CNT_W-1:0]  count_v  [NUM_CH];
    logic [CTRL_W-1:0] ctrl_v   [NUM_CH];
    logic [31:0]       rdata_d;
    logic              hit;
    logic              run_sel;

    assign run_sel = (int'(addr) == RUN_OFS);

    always_ff @(posedge clk) begin
        if (rst)                   run_q <= '0;
        else if (wr_en && run_sel) run_q <= wdata[NUM_CH-1:0];
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tmr_channel u_ch (
            .clk       (clk),
            .rst       (rst),
            .run       (run_q[i]),
            .reload_wr (wr_en && int'(addr) == reg_ofs(i, SUB_RELOAD)),
            .count_wr  (wr_en && int'(addr) == reg_ofs(i, SUB_COUNT)),
            .ctrl_wr   (wr_en && int'(addr) == reg_ofs(i, SUB_CTRL)),
            .wdata     (wdata),
            .reload_q  (reload_v[i]),
            .count_q   (count_v[i]),
            .ctrl_rd   (ctrl_v[i]),
            .irq       (irq[i])
        );
    end

    always_comb begin
        rdata_d = '0;
        hit     = run_sel;
        if (run_sel) rdata_d = 32'(run_q);
        for (int i = 0; i < NUM_CH; i++) begin
            if (int'(addr) == reg_ofs(i, SUB_RELOAD)) begin
                rdata_d = reload_v[i]; hit = 1'b1;
            end
            if (int'(addr) == reg_ofs(i, SUB_COUNT)) begin
                rdata_d = count_v[i]; hit = 1'b1;
            end
            if (int'(addr) == reg_ofs(i, SUB_CTRL)) begin
                rdata_d = 32'(ctrl_v[i]); hit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rdata_d;
    end

    // R2
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !hit) |=> (rdata == '0));
endmodule

// File: tb/tb_tmr_unit.sv
module tb_tmr_unit;
    localparam int NCH = 3;
    localparam int AW  = 8;
    localparam logic [AW-1:0] A_RUN = 8'd4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic           rd_en = 1'b0;
    logic [AW-1:0]  addr = '0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rdata;
    logic [NCH-1:0] irq;

    int checks = 0;
    int errors = 0;

    tmr_unit #(.NUM_CH(NCH), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic [2:0]  psc;
        logic        ie;
        logic [31:0] n;
        logic [31:0] k;
        logic [15:0] w;
        logic [31:0] exp_cnt;
        logic        exp_flag;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 1'b1, 32'd10, 32'd100,        16'd39,   32'd0,          1'b0}, // R4 R3
        '{3'd0, 1'b1, 32'd10, 32'd100,        16'd43,   32'd100,        1'b1}, // R6
        '{3'd1, 1'b0, 32'd2,  32'd5,          16'd79,   32'd3,          1'b1}, // R4 R6
        '{3'd2, 1'b1, 32'd1,  32'hFFFFFFFF,   16'd191,  32'hFFFFFFFE,   1'b1}, // R4 one-shot
        '{3'd3, 1'b0, 32'd7,  32'd9,          16'd255,  32'd6,          1'b0}, // R4
        '{3'd4, 1'b1, 32'd0,  32'd3,          16'd1023, 32'd3,          1'b1}, // R4 R6
        '{3'd5, 1'b1, 32'd50, 32'd9,          16'd300,  32'd50,         1'b0}, // R5
        '{3'd0, 1'b0, 32'd0,  32'd0,          16'd11,   32'd0,          1'b1}  // R6
    };

    function automatic logic [AW-1:0] ra(input int ch, input int sub);
        return AW'(8 + 12 * ch + sub);
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_RUN, d);          chk("R1 run", d, 32'h0);
        rd(ra(0, 8), d);       chk("R1 ctrl0", d, 32'h0);
        rd(ra(0, 4), d);       chk("R1 count0", d, 32'hFFFFFFFF);
        rd(ra(2, 0), d);       chk("R1 reload2", d, 32'hFFFFFFFF);
        chk("R1 irq", 32'(irq), 32'h0);

        // R2 unmapped offsets and run mask
        rd(8'd0, d);           chk("R2 ofs0", d, 32'h0);
        rd(8'd5, d);           chk("R2 ofs5", d, 32'h0);
        rd(8'd44, d);          chk("R2 ofs44", d, 32'h0);
        wr(A_RUN, 32'hFF);
        rd(A_RUN, d);          chk("R2 run mask", d, 32'h7);
        wr(A_RUN, 32'h0);

        // Table walk on channel 0
        for (int i = 0; i < 8; i++) begin
            wr(A_RUN, 32'h0);
            wr(ra(0, 8), 32'(VECS[i].psc) | (32'(VECS[i].ie) << 5));
            wr(ra(0, 0), VECS[i].k);
            wr(ra(0, 4), VECS[i].n);
            wr(A_RUN, 32'h1);
            repeat (int'(VECS[i].w)) @(negedge clk);
            wr(A_RUN, 32'h0);
            rd(ra(0, 4), d);   chk("R3/R4/R5/R6 count", d, VECS[i].exp_cnt);
            rd(ra(0, 8), d);   chk("R6 flag", 32'(d[8]), 32'(VECS[i].exp_flag));
            chk("R8 irq", 32'(irq[0]), 32'(VECS[i].exp_flag & VECS[i].ie));
        end

        // R7 sticky flag (flag is 1 after last vector)
        wr(ra(0, 8), 32'h100);
        rd(ra(0, 8), d);       chk("R7 write1 keeps", 32'(d[8]), 32'h1);
        wr(ra(0, 8), 32'h000);
        rd(ra(0, 8), d);       chk("R7 write0 clears", 32'(d[8]), 32'h0);
        wr(ra(0, 8), 32'h100);
        rd(ra(0, 8), d);       chk("R7 write1 no set", 32'(d[8]), 32'h0);

        // R8 interrupt gating and one-cycle delay
        wr(ra(0, 8), 32'h0);
        wr(ra(0, 0), 32'd5);
        wr(ra(0, 4), 32'd0);
        wr(A_RUN, 32'h1);
        repeat (3) @(negedge clk);
        wr(A_RUN, 32'h0);
        chk("R8 irq masked", 32'(irq[0]), 32'h0);
        wr(ra(0, 8), 32'h120);
        chk("R8 irq delay", 32'(irq[0]), 32'h0);
        @(negedge clk);
        chk("R8 irq raised", 32'(irq[0]), 32'h1);
        wr(ra(0, 8), 32'h020);
        @(negedge clk);
        chk("R8 irq cleared", 32'(irq[0]), 32'h0);

        // R9 prescaler phase restarts
        wr(ra(0, 8), 32'h0);
        wr(ra(0, 4), 32'd10);
        wr(A_RUN, 32'h1);
        @(negedge clk);
        wr(A_RUN, 32'h0);
        @(negedge clk);
        wr(A_RUN, 32'h1);
        repeat (2) @(negedge clk);
        wr(A_RUN, 32'h0);
        rd(ra(0, 4), d);       chk("R9 phase reset", d, 32'd10);

        // R10 independence, R3 hold while stopped
        wr(ra(1, 8), 32'h0);
        wr(ra(1, 4), 32'd20);
        wr(ra(0, 4), 32'd30);
        wr(A_RUN, 32'h2);
        repeat (7) @(negedge clk);
        wr(A_RUN, 32'h0);
        rd(ra(1, 4), d);       chk("R10 ch1 counted", d, 32'd18);
        rd(ra(0, 4), d);       chk("R10 ch0 untouched", d, 32'd30);
        repeat (20) @(negedge clk);
        rd(ra(1, 4), d);       chk("R3 hold stopped", d, 32'd18);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule